// File: doc/BRIEF.md
# Deskew Training Sequence Inserter

This block sits in the transmit word path of a source-synchronous packet link, between the burst framer upstream and the serializer downstream. Outside of training it is transparent: upstream words, each with its control flag, pass straight to the serializer under the serializer's ready handshake. When a training request arrives, the block waits for the current upstream burst to close, holds upstream back, and emits a deskew training sequence. A programmable 16-bit repeat count sets how many times the pattern repeats. The emitted sequence is padded with idle control words so that it fills a whole number of 16-byte (eight-word) burst cycles.

One repetition of the pattern is a single idle control word, then ten training control words, then ten training data words. A repeat count of zero turns insertion off, and any request seen while the count is zero is discarded. The count is copied when an insertion starts, so a write made during an insertion only affects the next one. A one-cycle done pulse follows the last word of the sequence.

The controller has six states. PASS forwards upstream words. LEAD_IDLE sends the idle word that opens each repetition. TR_CTL and TR_DATA each send ten words. PAD sends idle fill words. DONE raises the done pulse for one cycle. The transitions are as follows. PASS goes to LEAD_IDLE on a start, which needs a pending request, a nonzero count and no open upstream burst. LEAD_IDLE goes to TR_CTL when its word is accepted. TR_CTL goes to TR_DATA after its tenth word. TR_DATA goes back to LEAD_IDLE if repetitions remain. On the last repetition, TR_DATA goes to DONE if its last word closes an eight-word group and to PAD otherwise. PAD goes to DONE when it closes the group. DONE always returns to PASS.

Top module: `tpi_inserter`

## Requirements
- R1: After reset the repeat count is 0, out_valid and train_done are low, and up_ready follows out_ready.
- R2: Outside an insertion, out_valid, out_ctl and out_word equal up_valid, up_ctl and up_word, and up_ready equals out_ready.
- R3: A request made while the repeat count is 0 produces no training word and no done pulse, and it is discarded: a nonzero count written later does not start an insertion by itself.
- R4: An insertion starts only when no upstream burst is open. A burst opens with an accepted word that has up_last low and closes with an accepted word that has up_last high. A request made during a burst waits for the burst to close.
- R5: Each repetition is 21 words in this order: one idle word (out_ctl=1, out_word=0x000F), ten training control words (out_ctl=1, out_word=0x0FFF), and ten training data words (out_ctl=0, out_word=0xF000). The sequence holds exactly N repetitions, where N is the repeat count at the start.
- R6: After the last repetition, idle words (out_ctl=1, 0x000F) are appended until the sequence length is a multiple of 8 words (16 bytes). No padding is added when 21*N is already a multiple of 8.
- R7: up_ready stays low from the start cycle through the done cycle.
- R8: While out_ready is low, a training or pad word stays on out_word/out_ctl with out_valid high.
- R9: train_done is high for exactly one cycle, the cycle after the final word is accepted, and out_valid is low in that cycle.
- R10: A repeat count written during an insertion does not change that insertion's length and takes effect at the next insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the repeat count |
| cfg_count | input | 16 | Repeat count value to write |
| train_req | input | 1 | One-cycle training request |
| up_valid | input | 1 | Upstream word valid |
| up_ctl | input | 1 | Upstream control flag |
| up_word | input | 16 | Upstream word |
| up_last | input | 1 | Upstream word closes its burst |
| up_ready | output | 1 | Block can take an upstream word |
| out_valid | output | 1 | Output word valid |
| out_ctl | output | 1 | Output control flag |
| out_word | output | 16 | Output word |
| out_ready | input | 1 | Serializer accepts the output word |
| train_done | output | 1 | One-cycle pulse after the sequence ends |

## Verification
The bench builds the block with its default parameters: a 16-bit count, 8-word bursts, and ten control words and ten data words per repetition. Repeat counts of 1 through 9 are used. Because 21 and 8 share no factor, these counts produce every pad length from zero to seven, and the count of 8 gives the exact-fit case with no padding. Random serializer back-pressure and random upstream bursts of one to eight words make requests land in the middle of bursts and stall words inside the pattern.

// File: rtl/tpi_pkg.sv
package tpi_pkg;
    localparam int WORD_W = 16;

    localparam logic [WORD_W-1:0] IDLE_CODE  = 16'h000F;
    localparam logic [WORD_W-1:0] TCTL_CODE  = 16'h0FFF;
    localparam logic [WORD_W-1:0] TDATA_CODE = 16'hF000;

    typedef enum logic [2:0] {
        ST_PASS,
        ST_LEAD_IDLE,
        ST_TR_CTL,
        ST_TR_DATA,
        ST_PAD,
        ST_DONE
    } tpi_state_e;
endpackage

// File: rtl/tpi_cfg.sv
module tpi_cfg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_val,
    input  logic             req,
    input  logic             consume,
    output logic [CNT_W-1:0] cfg_q,
    output logic             pending_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            pending_q <= 1'b0;
        end else begin
            if (cfg_we)
                cfg_q <= cfg_val;
            if (req)
                pending_q <= 1'b1;
            else if (consume)
                pending_q <= 1'b0;
        end
    end

    AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !req) |=> !pending_q); // R3
endmodule

// File: rtl/tpi_burst_track.sv
module tpi_burst_track (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic last,
    output logic in_burst_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_burst_q <= 1'b0;
        else if (fire)
            in_burst_q <= !last;
    end
endmodule

// File: rtl/tpi_fsm.sv
module tpi_fsm
    import tpi_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BURST_WORDS = 8,
    parameter int CTL_LEN     = 10,
    parameter int DATA_LEN    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_reps,
    input  logic             out_ready,
    output tpi_state_e       state_q
);
    localparam int MAX_LEN = (CTL_LEN > DATA_LEN) ? CTL_LEN : DATA_LEN;
    localparam int SUB_W   = $clog2(MAX_LEN);
    localparam int POS_W   = $clog2(BURST_WORDS);

    tpi_state_e       state_d;
    logic [SUB_W-1:0] sub_q, sub_d;
    logic [CNT_W-1:0] reps_q, reps_d;
    logic [POS_W-1:0] pos_q, pos_d, pos_inc;
    logic             pos_last;

    assign pos_last = (pos_q == POS_W'(BURST_WORDS - 1));
    assign pos_inc  = pos_last ? '0 : pos_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            sub_q   <= '0;
            reps_q  <= '0;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            sub_q   <= sub_d;
            reps_q  <= reps_d;
            pos_q   <= pos_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sub_d   = sub_q;
        reps_d  = reps_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_PASS: begin
                if (start) begin
                    state_d = ST_LEAD_IDLE;
                    reps_d  = load_reps;
                    pos_d   = '0;
                    sub_d   = '0;
                end
            end
            ST_LEAD_IDLE: begin
                if (out_ready) begin
                    state_d = ST_TR_CTL;
                    sub_d   = '0;
                    pos_d   = pos_inc;
                end
            end
            ST_TR_CTL: begin
                if (out_ready) begin
                    pos_d = pos_inc;
                    if (sub_q == SUB_W'(CTL_LEN - 1)) begin
                        state_d = ST_TR_DATA;
                        sub_d   = '0;
                    end else begin
                        sub_d = sub_q + 1'b1;
                    end
                end
            end
            ST_TR_DATA: begin
                if (out_ready) begin
                    pos_d = pos_inc;
                    if (sub_q == SUB_W'(DATA_LEN - 1)) begin
                        sub_d = '0;
                        if (reps_q == CNT_W'(1)) begin
                            state_d = pos_last ? ST_DONE : ST_PAD;
                        end else begin
                            reps_d  = reps_q - 1'b1;
                            state_d = ST_LEAD_IDLE;
                        end
                    end else begin
                        sub_d = sub_q + 1'b1;
                    end
                end
            end
            ST_PAD: begin
                if (out_ready) begin
                    pos_d = pos_inc;
                    if (pos_last)
                        state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_PASS;
            end
            default: begin
                state_d = ST_PASS;
            end
        endcase
    end

    AST_DONE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (pos_q == '0)); // R6
    AST_DONE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |=> (state_q == ST_PASS)); // R9
    AST_REPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD_IDLE || state_q == ST_TR_CTL || state_q == ST_TR_DATA)
        |-> (reps_q != '0)); // R5
    AST_PAD_ONLY_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAD) |-> (pos_q != '0)); // R6
endmodule

// File: rtl/tpi_inserter.sv
module tpi_inserter
    import tpi_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BURST_WORDS = 8,
    parameter int CTL_LEN     = 10,
    parameter int DATA_LEN    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              train_req,
    input  logic              up_valid,
    input  logic              up_ctl,
    input  logic [WORD_W-1:0] up_word,
    input  logic              up_last,
    output logic              up_ready,
    output logic              out_valid,
    output logic              out_ctl,
    output logic [WORD_W-1:0] out_word,
    input  logic              out_ready,
    output logic              train_done
);
    logic [CNT_W-1:0] cfg_q;
    logic             pending_q;
    logic             in_burst_q;
    logic             start, drop;
    tpi_state_e       state_q;

    assign start = (state_q == ST_PASS) && pending_q && (cfg_q != '0) && !in_burst_q;
    assign drop  = (state_q == ST_PASS) && pending_q && (cfg_q == '0);

    tpi_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_val   (cfg_count),
        .req       (train_req),
        .consume   (start | drop),
        .cfg_q     (cfg_q),
        .pending_q (pending_q)
    );

    tpi_burst_track u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (up_valid && up_ready),
        .last       (up_last),
        .in_burst_q (in_burst_q)
    );

    tpi_fsm #(
        .CNT_W       (CNT_W),
        .BURST_WORDS (BURST_WORDS),
        .CTL_LEN     (CTL_LEN),
        .DATA_LEN    (DATA_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_reps (cfg_q),
        .out_ready (out_ready),
        .state_q   (state_q)
    );

    always_comb begin
        out_valid  = 1'b0;
        out_ctl    = 1'b1;
        out_word   = IDLE_CODE;
        up_ready   = 1'b0;
        train_done = 1'b0;
        unique case (state_q)
            ST_PASS: begin
                out_valid = up_valid && !start;
                out_ctl   = up_ctl;
                out_word  = up_word;
                up_ready  = out_ready && !start;
            end
            ST_LEAD_IDLE, ST_PAD: begin
                out_valid = 1'b1;
            end
            ST_TR_CTL: begin
                out_valid = 1'b1;
                out_word  = TCTL_CODE;
            end
            ST_TR_DATA: begin
                out_valid = 1'b1;
                out_ctl   = 1'b0;
                out_word  = TDATA_CODE;
            end
            ST_DONE: begin
                train_done = 1'b1;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    AST_UP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PASS) |-> !up_ready); // R7
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && state_q != ST_PASS)
        |=> (out_valid && $stable(out_word) && $stable(out_ctl))); // R8
    AST_NO_MIDBURST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && in_burst_q) |=> (state_q == ST_PASS)); // R4
    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && cfg_q == '0) |=> (state_q == ST_PASS)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        train_done |=> !train_done); // R9
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        train_done |-> (!out_valid && !up_ready)); // R9
endmodule

// File: tb/tpi_inserter_tb.sv
module tpi_inserter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int REP_WORDS  = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_count = '0;
    logic        train_req = 1'b0;
    logic        up_valid = 1'b0;
    logic        up_ctl = 1'b0;
    logic [15:0] up_word = '0;
    logic        up_last = 1'b0;
    logic        up_ready;
    logic        out_valid;
    logic        out_ctl;
    logic [15:0] out_word;
    logic        out_ready = 1'b1;
    logic        train_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpi_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_count(cfg_count),
        .train_req(train_req), .up_valid(up_valid), .up_ctl(up_ctl),
        .up_word(up_word), .up_last(up_last), .up_ready(up_ready),
        .out_valid(out_valid), .out_ctl(out_ctl), .out_word(out_word),
        .out_ready(out_ready), .train_done(train_done)
    );

    int checks = 0;
    int errors = 0;
    int model_cfg = 0;
    int exp_n = 0;
    int idx = 0;
    int tr_words = 0;
    int done_cnt = 0;
    int last_len = 0;
    bit tr_active = 0;
    bit in_burst_b = 0;
    bit up_acc = 0;
    bit gen_en = 0;
    bit rdy_force = 1;
    bit prev_stall = 0;
    logic [16:0] prev_word = '0;
    int blen = 0;
    int seq = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pad8(input int n);
        return ((REP_WORDS * n + 7) / 8) * 8;
    endfunction

    function automatic logic [16:0] exp_word(input int i, input int n);
        int r;
        if (i >= REP_WORDS * n) return {1'b1, 16'h000F};
        r = i % REP_WORDS;
        if (r == 0)  return {1'b1, 16'h000F};
        if (r <= 10) return {1'b1, 16'h0FFF};
        return {1'b0, 16'hF000};
    endfunction

    // Stimulus: upstream bursts and serializer ready, driven after the edge
    always @(posedge clk) begin
        #1;
        out_ready = rdy_force ? 1'b1 : ($urandom_range(0, 9) < 7);
        if (up_acc) begin
            up_acc   = 0;
            up_valid = 1'b0;
        end
        if (!up_valid && gen_en && $urandom_range(0, 3) != 0) begin
            if (blen == 0) blen = $urandom_range(1, 8);
            up_word  = 16'(seq) & 16'h7FFF;
            seq++;
            up_last  = (blen == 1);
            blen--;
            up_valid = 1'b1;
        end
    end

    // Monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [16:0] w;
            bit is_tr;
            w = {out_ctl, out_word};
            is_tr = out_valid && (out_ctl || out_word[15]);
            if (tr_active)
                chk(!up_ready, "R7 up_ready during insertion", up_ready, 0);
            if (is_tr) begin
                if (!tr_active) begin
                    tr_active = 1;
                    idx = 0;
                    exp_n = model_cfg;
                    prev_stall = 0;
                    chk(!in_burst_b, "R4 start inside open burst", in_burst_b, 0);
                end
                if (prev_stall)
                    chk(w == prev_word, "R8 word changed while stalled", w, prev_word);
                chk(w == exp_word(idx, exp_n), (idx < REP_WORDS * exp_n) ? "R5 pattern word" : "R6 pad word",
                    w, exp_word(idx, exp_n));
                prev_stall = !out_ready;
                prev_word = w;
                if (out_ready) begin
                    idx++;
                    tr_words++;
                end
            end else if (out_valid) begin
                chk(up_valid && w == {up_ctl, up_word}, "R2 passthrough word", w, {up_ctl, up_word});
                chk(up_ready == out_ready, "R2 ready passthrough", up_ready, out_ready);
            end
            if (train_done) begin
                chk(tr_active, "R9 done without insertion", tr_active, 1);
                chk(idx == pad8(exp_n), "R6 sequence length", idx, pad8(exp_n));
                chk(!out_valid, "R9 out_valid in done cycle", out_valid, 0);
                last_len = idx;
                tr_active = 0;
                done_cnt++;
            end
            if (up_valid && up_ready) begin
                in_burst_b = !up_last;
                up_acc = 1;
            end
        end
    end

    task automatic write_cfg(input int v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_count = 16'(v);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        model_cfg = v;
    endtask

    task automatic request();
        @(posedge clk); #1;
        train_req = 1'b1;
        @(posedge clk); #1;
        train_req = 1'b0;
    endtask

    task automatic wait_done();
        int d;
        d = done_cnt;
        while (done_cnt == d) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R9 watchdog, insertion never completed", done_cnt, done_cnt + 1);
        summary();
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
        chk(!train_done, "R1 train_done after reset", train_done, 0);
        chk(up_ready == out_ready, "R1 up_ready follows out_ready", up_ready, out_ready);

        // R3: zero count ignores the request, and the request is dropped
        gen_en = 1;
        rdy_force = 0;
        request();
        repeat (40) @(posedge clk);
        chk(tr_words == 0, "R3 training with zero count", tr_words, 0);
        chk(done_cnt == 0, "R3 done with zero count", done_cnt, 0);
        write_cfg(2);
        repeat (40) @(posedge clk);
        chk(tr_words == 0, "R3 dropped request restarted", tr_words, 0);
        chk(done_cnt == 0, "R3 done after dropped request", done_cnt, 0);

        // R10: write during insertion applies only to the next one
        base = tr_words;
        request();
        while (tr_words < base + 10) @(posedge clk);
        write_cfg(3);
        wait_done();
        chk(last_len == pad8(2), "R10 length kept during insertion", last_len, pad8(2));
        request();
        wait_done();
        chk(last_len == pad8(3), "R10 new count at next insertion", last_len, pad8(3));

        // R6: exact fit and minimum count
        write_cfg(8);
        request();
        wait_done();
        chk(last_len == 168, "R6 exact fit without padding", last_len, 168);
        write_cfg(1);
        request();
        wait_done();
        chk(last_len == 24, "R6 single repetition padded", last_len, 24);

        // Random counts, traffic and back-pressure
        for (int k = 0; k < 20; k++) begin
            int v;
            v = $urandom_range(1, 9);
            write_cfg(v);
            repeat ($urandom_range(0, 12)) @(posedge clk);
            request();
            wait_done();
            chk(last_len == pad8(v), "R5 random insertion length", last_len, pad8(v));
        end

        gen_en = 0;
        repeat (20) @(posedge clk);
        summary();
        $finish;
    end
endmodule